// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple word requester and an asynchronous DRAM whose row and column addresses share one set of address pins. Each accepted request is turned into a sequence of active-low strobes: a row strobe with the row address on the pins, then a column strobe with the column address. Reads put the DRAM output enable low. Writes put the write enable low and drive the shared data bus before the column strobe falls. The shared data bus is modelled as separate input, output and output-enable signals.

After an access the row strobe stays low, so the row remains open. A later request to the same row skips the row phase and only strobes the column. A request to another row first raises the row strobe for a precharge interval and then opens the new row. The four DRAM timing limits are given in nanoseconds as parameters, together with the clock period, and are rounded up to whole clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The upper ROW_W bits of `req_addr` form the row and the lower COL_W bits form the column. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls.
- R3: When a row is opened, `dram_cas_n` falls exactly ceil(RAC_NS/CLK_NS) - ceil(CAC_NS/CLK_NS) cycles after `dram_ras_n` falls (6 cycles at the defaults).
- R4: A read samples `dram_dq_in` only after `dram_cas_n` has been low for ceil(CAC_NS/CLK_NS) cycles. The sampled word then appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R5: For a write, `dram_we_n` is low and `dram_dq_oe` is high in the cycle before `dram_cas_n` falls (early write), and `dram_dq_out` carries the request's write data.
- R6: A request to the row that is already open causes no new fall of `dram_ras_n`. The row strobe stays low and only `dram_cas_n` is strobed.
- R7: A request to a different row raises `dram_ras_n` for exactly ceil(RC_NS/CLK_NS) - ceil(RAC_NS/CLK_NS) cycles (6 at the defaults) before it falls again.
- R8: Between two column strobes, `dram_cas_n` stays high for at least ceil(PC_NS/CLK_NS) - ceil(CAC_NS/CLK_NS) cycles.
- R9: `dram_oe_n` is never low while `dram_we_n` is low or `dram_dq_oe` is high. When idle, `dram_dq_oe` is 0 and the bus is released.
- R10: `req_ready` is high only while the controller is idle. It is never high while `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address pins |
| dram_dq_out | output | DW | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the shared data bus |
| dram_dq_in | input | DW | Data from the DRAM |

## Verification
Two decisions can meet in one cycle. The page-hit test compares the incoming row with the open row, while the open-row register is updated for a row being opened. The precharge start that closes the page also depends on that comparison. The bench provokes both by issuing a request to the open row right after an access completes, and a request to another row right after an access to the open row. It judges the outcome by counting row-strobe falls and measuring the precharge length at the pins, and by checking that the read data came from the intended row and column of a behavioural DRAM model. The model returns junk until the column strobe has been low for the column access time.

// File: rtl/fpm_pkg.sv
// Shared types and cycle helpers for the page-mode DRAM controller.
// Assumes timing parameters are positive integers in nanoseconds.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting; row may still be open
        ST_PRE,    // row strobe high, precharging
        ST_ROW,    // row strobe low, row address on pins
        ST_CSET,   // column address and write setup, column strobe high
        ST_CSTR,   // column strobe low
        ST_CREC    // column strobe high, recovery before next column
    } fpm_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
// Down-counting phase timer. Loading N-1 makes done rise after N cycles.
// Assumes load_val fits TW bits; holds at zero when expired.
module fpm_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    // Count down the current phase length.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R3: phase lengths come from a strict one-per-cycle countdown
    a_r3_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fpm_page_track.sv
// Keeps the open row and a page-open flag; flags a hit for a lookup row.
// Assumes open and close requests never arrive in the same cycle.
module fpm_page_track #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] lookup_row,
    output logic             page_open,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);

    // Record which row is held open by the DRAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open <= 1'b0;
            open_row  <= '0;
        end else if (open_en) begin
            page_open <= 1'b1;
            open_row  <= row_in;
        end else if (close_en) begin
            page_open <= 1'b0;
        end
    end

    assign hit = page_open && (open_row == lookup_row);

    // R6: the open row only changes when a new row is opened
    a_r6_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        (page_open && !open_en) |=> $stable(open_row));

endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode DRAM controller: converts word requests into row/column strobe
// sequences on a multiplexed address bus, keeping the row open between
// accesses. Assumes one outstanding request; refresh is handled elsewhere.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int COL_W  = 9,
    parameter int DW     = 16,
    parameter int CLK_NS = 8,
    parameter int RAC_NS = 60,
    parameter int RC_NS  = 110,
    parameter int CAC_NS = 15,
    parameter int PC_NS  = 35
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int RAC_CYC = ceil_div(RAC_NS, CLK_NS);
    localparam int RC_CYC  = ceil_div(RC_NS, CLK_NS);
    localparam int CAC_CYC = ceil_div(CAC_NS, CLK_NS);
    localparam int PC_CYC  = ceil_div(PC_NS, CLK_NS);
    localparam int ROW_CYC = at_least_one(RAC_CYC - CAC_CYC - 1);
    localparam int STR_CYC = at_least_one(CAC_CYC);
    localparam int REC_CYC = at_least_one(PC_CYC - CAC_CYC - 1);
    localparam int PRE_CYC = at_least_one(RC_CYC - RAC_CYC);
    localparam int TMAX    = imax(imax(ROW_CYC, STR_CYC), imax(REC_CYC, PRE_CYC));
    localparam int TW      = $clog2(TMAX + 1);
    localparam int PW      = $clog2(PRE_CYC + 1);

    fpm_state_e       state_q, state_d;
    logic             op_we_q;
    logic [ROW_W-1:0] op_row_q;
    logic [COL_W-1:0] op_col_q;
    logic [DW-1:0]    op_wdata_q;
    logic             rsp_valid_q;
    logic [DW-1:0]    rsp_rdata_q;

    logic             accept;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             tmr_load, tmr_done;
    logic [TW-1:0]    tmr_val;
    logic             pg_open, pg_hit, pg_open_en, pg_close_en;
    logic [ROW_W-1:0] pg_open_row, pg_row_in;
    logic             col_phase;

    assign req_row   = req_addr[ADDR_W-1 -: ROW_W];
    assign req_col   = req_addr[COL_W-1:0];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    fpm_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done)
    );

    fpm_page_track #(.ROW_W(ROW_W)) u_page (
        .clk(clk), .rst_n(rst_n), .open_en(pg_open_en), .close_en(pg_close_en),
        .row_in(pg_row_in), .lookup_row(req_row), .page_open(pg_open),
        .open_row(pg_open_row), .hit(pg_hit)
    );

    // Choose the next phase and its length.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (pg_hit) begin
                    state_d = ST_CSET;
                end else if (pg_open) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PRE_CYC - 1);
                end else begin
                    state_d  = ST_ROW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ROW_CYC - 1);
                end
            end
            ST_PRE: if (tmr_done) begin
                state_d  = ST_ROW;
                tmr_load = 1'b1;
                tmr_val  = TW'(ROW_CYC - 1);
            end
            ST_ROW: if (tmr_done) state_d = ST_CSET;
            ST_CSET: begin
                state_d  = ST_CSTR;
                tmr_load = 1'b1;
                tmr_val  = TW'(STR_CYC - 1);
            end
            ST_CSTR: if (tmr_done) begin
                state_d  = ST_CREC;
                tmr_load = 1'b1;
                tmr_val  = TW'(REC_CYC - 1);
            end
            ST_CREC: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Open-row bookkeeping follows the phase transitions.
    assign pg_open_en  = (state_d == ST_ROW) && (state_q != ST_ROW);
    assign pg_close_en = (state_d == ST_PRE) && (state_q != ST_PRE);
    assign pg_row_in   = (state_q == ST_IDLE) ? req_row : op_row_q;

    // Phase register and the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_we_q    <= 1'b0;
            op_row_q   <= '0;
            op_col_q   <= '0;
            op_wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_we_q    <= req_we;
                op_row_q   <= req_row;
                op_col_q   <= req_col;
                op_wdata_q <= req_wdata;
            end
        end
    end

    // Capture read data at the end of the column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= (state_q == ST_CSTR) && tmr_done && !op_we_q;
            if ((state_q == ST_CSTR) && tmr_done && !op_we_q)
                rsp_rdata_q <= dram_dq_in;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    // Decode the DRAM pins from the phase.
    assign col_phase = (state_q == ST_CSET) || (state_q == ST_CSTR);
    always_comb begin
        dram_ras_n = !((state_q == ST_ROW) || col_phase || (state_q == ST_CREC) ||
                       ((state_q == ST_IDLE) && pg_open));
        dram_cas_n = !(state_q == ST_CSTR);
        dram_we_n  = !(col_phase && op_we_q);
        dram_oe_n  = !(col_phase && !op_we_q);
        dram_dq_oe = col_phase && op_we_q;
        dram_addr  = '0;
        if (state_q == ST_ROW) dram_addr = PIN_W'(op_row_q);
        else if (col_phase)    dram_addr = PIN_W'(op_col_q);
    end
    assign dram_dq_out = op_wdata_q;

    // Checker state: cycles the row strobe has been high, saturating.
    logic [PW-1:0] ras_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                         ras_hi_cnt <= PW'(PRE_CYC);
        else if (!dram_ras_n)               ras_hi_cnt <= '0;
        else if (ras_hi_cnt < PW'(PRE_CYC)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    a_r7_precharge_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= PW'(PRE_CYC)));

    a_r2_row_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (dram_addr == PIN_W'(pg_open_row)));

    a_r5_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe)));

    a_r6_hit_keeps_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pg_hit) |=> (!dram_ras_n && $past(!dram_ras_n)));

    a_r9_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_dq_oe));

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_cas_n && !dram_dq_oe));

    a_r4_rsp_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!dram_cas_n));

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench with a behavioural page-mode DRAM model.
module fpm_dram_ctrl_bench;

    localparam int RW = 4;
    localparam int CW = 4;
    localparam int DW = 16;
    localparam int E_GAP    = 6;   // 8 - 2 cycles, ras fall to cas fall
    localparam int E_PRE    = 6;   // 14 - 8 cycles of precharge
    localparam int E_CASHI  = 3;   // 5 - 2 cycles minimum cas high
    localparam int E_CAC    = 2;   // cycles of cas low before data valid

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [RW+CW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [3:0] dram_addr;
    logic [DW-1:0] dq_out, dq_in;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(.ROW_W(RW), .COL_W(CW), .DW(DW)) u_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
        .dram_dq_in(dq_in)
    );

    int checks = 0, errors = 0;
    int cyc = 0, ras_falls = 0, ras_fall_cyc = 0, ras_rise_cyc = 0;
    int cas_rise_cyc = 0, last_gap = 0, last_pre = 0, min_cas_hi = 1000;
    int cas_lo = 0, early_wr = 0, late_wr = 0, conflicts = 0, ready_busy = 0;
    bit have_rise = 0, have_crise = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
    logic [RW-1:0] mrow = '0;
    logic [CW-1:0] mcol = '0;
    logic [DW-1:0] mem [256];

    // DRAM model: data valid only after cas has been low E_CAC cycles.
    assign dq_in = (cas_lo >= E_CAC && !oe_n && we_n) ? mem[{mrow, mcol}] : 16'hDEAD;

    // Pin monitor and model, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
        end else begin
            cyc++;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                if (have_rise) last_pre = cyc - ras_rise_cyc;
                ras_fall_cyc = cyc;
                mrow = dram_addr[RW-1:0];
            end
            if (!prev_ras && ras_n) begin ras_rise_cyc = cyc; have_rise = 1; end
            if (prev_cas && !cas_n) begin
                last_gap = cyc - ras_fall_cyc;
                if (have_crise && (cyc - cas_rise_cyc) < min_cas_hi)
                    min_cas_hi = cyc - cas_rise_cyc;
                mcol = dram_addr[CW-1:0];
                if (!we_n) begin
                    if (!prev_we && dq_oe) early_wr++; else late_wr++;
                    mem[{mrow, dram_addr[CW-1:0]}] = dq_out;
                end
            end
            if (!prev_cas && cas_n) begin cas_rise_cyc = cyc; have_crise = 1; end
            if (!cas_n) cas_lo++; else cas_lo = 0;
            if ((dq_oe && !oe_n) || (!we_n && !oe_n)) conflicts++;
            if (req_ready && !cas_n) ready_busy++;
        end
        prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic issue(input logic we, input logic [RW-1:0] row,
                         input logic [CW-1:0] col, input logic [DW-1:0] wd);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = {row, col}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic rd(input logic [RW-1:0] row, input logic [CW-1:0] col,
                      output logic [DW-1:0] d);
        int n = 0;
        issue(1'b0, row, col, '0);
        while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
        d = rsp_valid ? rsp_rdata : 16'hFFFF;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 ras_n", int'(ras_n), 1);
        chk("R1 cas_n", int'(cas_n), 1);
        chk("R1 we_n", int'(we_n), 1);
        chk("R1 oe_n", int'(oe_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
    endtask

    task automatic t_closed_write();
        issue(1'b1, 4'd3, 4'd5, 16'hA5A5);
        wait_idle();
        chk("R3 one row open", ras_falls, 1);
        chk("R3 ras-to-cas cycles", last_gap, E_GAP);
        chk("R5 early write", early_wr, 1);
        chk("R5 no late write", late_wr, 0);
        chk("R2 written cell", int'(mem[{4'd3, 4'd5}]), 16'hA5A5);
    endtask

    task automatic t_hit_read();
        logic [DW-1:0] d;
        rd(4'd3, 4'd5, d);
        chk("R4 read data", int'(d), 16'hA5A5);
        chk("R6 no new row strobe", ras_falls, 1);
    endtask

    task automatic t_hit_burst();
        logic [DW-1:0] d;
        issue(1'b1, 4'd3, 4'd6, 16'h1111);
        issue(1'b1, 4'd3, 4'd7, 16'h2222);
        rd(4'd3, 4'd7, d);
        chk("R4 burst read col7", int'(d), 16'h2222);
        rd(4'd3, 4'd6, d);
        chk("R4 burst read col6", int'(d), 16'h1111);
        rd(4'd3, 4'd9, d);
        chk("R2 untouched column", int'(d), 16'h1039);
        chk("R6 burst kept row", ras_falls, 1);
        chk_ge("R8 cas high between strobes", min_cas_hi, E_CASHI);
    endtask

    task automatic t_miss();
        logic [DW-1:0] d;
        issue(1'b1, 4'd9, 4'd5, 16'hBEEF);
        wait_idle();
        chk("R7 row reopened", ras_falls, 2);
        chk("R7 precharge cycles", last_pre, E_PRE);
        chk("R3 gap after miss", last_gap, E_GAP);
        rd(4'd3, 4'd5, d);
        chk("R2 row 3 after miss", int'(d), 16'hA5A5);
        rd(4'd9, 4'd5, d);
        chk("R2 row 9 data", int'(d), 16'hBEEF);
        chk("R7 miss count", ras_falls, 4);
    endtask

    task automatic t_idle_bus();
        repeat (5) @(negedge clk);
        chk("R9 bus released idle", int'(dq_oe), 0);
        chk("R9 no bus conflict", conflicts, 0);
        chk("R10 ready idle", int'(req_ready), 1);
        chk("R10 never ready while busy", ready_busy, 0);
    endtask

    int wd_cnt = 0;
    always @(negedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_closed_write();
        t_hit_read();
        t_hit_burst();
        t_miss();
        t_idle_bus();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule